// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the software-visible side of a UART. A host reaches it through a simple word-addressed bus inside a 4 KB window. Read data comes back registered, one cycle after the access. Received bytes arrive on a byte-wide valid/ready port and go into a 16-entry circular queue. Software drains the queue by reading the data register. A write to the data register sends its low byte out as a one-cycle transmit strobe. The block has no serial framing, no baud tick generation, no DMA and no loopback. The divisor, line and control registers only hold what is written to them.

The block keeps raw interrupt bits for transmit (bit 5) and receive (bit 4), a mask register and a single level interrupt output. The receive bit follows the queue occupancy against a threshold. Line-control bit 4 selects a queue depth of sixteen entries, or a depth of one when the bit is clear. The top of the window holds eight read-only identification bytes.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the flag word reads 0x90, the level-select register reads 0x12, the control register reads 0x300 and every other register reads 0. After reset, `irq`, `tx_strobe` and `bus_rdata` are low and `rx_ready` is high.
- R2: Word index = byte address >> 2. The map is: 0 data, 6 flags, 8 low-power divisor (8 bits), 9 integer divisor (16 bits), 10 fractional divisor (6 bits), 11 line control (8 bits), 12 control (16 bits), 13 level select (6 bits), 14 mask (11 bits), 15 raw status, 16 masked status, 17 clear (write-only), 18 DMA control (3 bits). Storage registers read back their written value truncated to the stated width. Writes to the flag word, to the identification area or to unmapped indices change no register. Reads of unmapped indices return 0.
- R3: Byte addresses 0xFE0 through 0xFFC each return one identification byte, in the order 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: `rx_ready` is high while the count is below 16 when line-control bit 4 is 1, and only while the count is 0 when that bit is 0. A byte offered while `rx_ready` is low is dropped.
- R5: Accepted bytes are stored at (read pointer + count) mod 16 and come back from data reads in arrival order, including across the wrap of the pointer.
- R6: Flag bit 4 (receive empty) is 1 exactly when the count is 0. Flag bit 6 (receive full) sets when the count reaches 16 and clears on any data read. Bit 7 (transmit empty) always reads 1 and bit 5 (transmit full) always reads 0.
- R7: Raw bit 4 sets when an accepted byte brings the count up to the threshold (1). It clears when a data read brings the count down to threshold minus 1.
- R8: A data-register write pulses `tx_strobe` for one cycle in the next cycle, with `tx_byte` equal to the low write byte, and sets raw bit 5.
- R9: `irq` is high exactly when raw status AND mask is nonzero, from the cycle after a mask or status change. The masked-status read returns that AND.
- R10: A write to the clear register clears every raw bit written as 1 and leaves the other bits unchanged.
- R11: A data read while the queue is empty returns the entry at the read pointer and changes neither the pointer nor the count.
- R12: Read data appears on `bus_rdata` in the cycle after the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte accepted this cycle if valid |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the queue so that the pointer wraps, then drains it. A design with a wrong pointer modulo returns the bytes out of order, and one that never sets the full flag reports 0x80 instead of 0xC0. The bench reads the empty queue after a full cycle. That read must return the old slot and leave the pointer where it is; a design that decrements anyway shifts every later byte. In single-entry mode a second byte is offered while `rx_ready` is low, and a design that takes it loses the first byte or returns an extra one. Clear and mask writes are checked on each interrupt bit alone, which exposes a clear that hits the wrong bit or an interrupt output that ignores the mask.

// File: rtl/urf_pkg.sv
package urf_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int IRQ_W  = 11;

  localparam logic [IDX_W-1:0] IX_DATA  = 10'd0;
  localparam logic [IDX_W-1:0] IX_FLAG  = 10'd6;
  localparam logic [IDX_W-1:0] IX_LPDIV = 10'd8;
  localparam logic [IDX_W-1:0] IX_IDIV  = 10'd9;
  localparam logic [IDX_W-1:0] IX_FDIV  = 10'd10;
  localparam logic [IDX_W-1:0] IX_LINE  = 10'd11;
  localparam logic [IDX_W-1:0] IX_CTRL  = 10'd12;
  localparam logic [IDX_W-1:0] IX_LVL   = 10'd13;
  localparam logic [IDX_W-1:0] IX_MASK  = 10'd14;
  localparam logic [IDX_W-1:0] IX_RAW   = 10'd15;
  localparam logic [IDX_W-1:0] IX_MSTAT = 10'd16;
  localparam logic [IDX_W-1:0] IX_CLR   = 10'd17;
  localparam logic [IDX_W-1:0] IX_DMA   = 10'd18;

  localparam int BIT_TXI = 5;
  localparam int BIT_RXI = 4;
  localparam int LINE_QEN = 4;

  function automatic logic [7:0] id_byte(input logic [2:0] n);
    case (n)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/urf_rx_queue.sv
module urf_rx_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rp_q, rp_d, wp;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pop_ok;

  assign pop_ok = pop && (cnt_q != '0);
  assign wp     = PTR_W'((CNT_W'(rp_q) + cnt_q) % CNT_W'(DEPTH));
  assign head   = mem[rp_q];
  assign count  = cnt_q;

  always_comb begin
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (pop_ok) rp_d = PTR_W'((CNT_W'(rp_q) + CNT_W'(1)) % CNT_W'(DEPTH));
    if (push && !pop_ok) cnt_d = cnt_q + CNT_W'(1);
    else if (pop_ok && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_ok) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r11_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0 && $stable(rp_q)));
endmodule

// File: rtl/urf_irq.sv
module urf_irq #(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] set_vec,
  input  logic [IW-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [IW-1:0] mask_wdata,
  output logic [IW-1:0] raw,
  output logic [IW-1:0] mask,
  output logic          irq
);
  logic [IW-1:0] raw_q, raw_d, mask_q, mask_d;

  always_comb begin
    raw_d  = (raw_q & ~clr_vec) | set_vec;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = |(raw_q & mask_q);

  a_r10_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(clr_vec) & ~$past(set_vec)) == '0));
  a_r10_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(raw_q) & ~$past(clr_vec)) == ($past(raw_q) & ~$past(clr_vec))));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import urf_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int RX_TRIG = 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [7:0]        tx_byte,
  output logic              irq
);
  logic [IDX_W-1:0] idx;
  logic             in_id, rd, wr, data_rd, data_wr, push, pop_eff;
  logic [7:0]       head;
  logic [CNT_W-1:0] count;
  logic [IRQ_W-1:0] raw, mask, set_vec, clr_vec;

  logic [7:0]  lpdiv_q, line_q;
  logic [15:0] idiv_q, ctrl_q;
  logic [5:0]  fdiv_q, lvl_q;
  logic [2:0]  dma_q;
  logic        full_q, full_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic        txs_q;
  logic [7:0]  txb_q;
  logic [7:0]  flags;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign in_id   = (bus_addr[ADDR_W-1:5] == '1);
  assign rd      = bus_sel && !bus_wr;
  assign wr      = bus_sel && bus_wr;
  assign data_rd = rd && !in_id && (idx == IX_DATA);
  assign data_wr = wr && !in_id && (idx == IX_DATA);

  assign rx_ready = line_q[LINE_QEN] ? (count < CNT_W'(DEPTH)) : (count == '0);
  assign push     = rx_valid && rx_ready;
  assign pop_eff  = data_rd && (count != '0);

  urf_rx_queue #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_data),
    .pop(data_rd), .head(head), .count(count));

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (wr && !in_id && idx == IX_CLR) clr_vec = bus_wdata[IRQ_W-1:0];
    if (pop_eff && !push && count == CNT_W'(RX_TRIG)) clr_vec[BIT_RXI] = 1'b1;
    if (push && !pop_eff && (count + CNT_W'(1)) == CNT_W'(RX_TRIG)) set_vec[BIT_RXI] = 1'b1;
    if (data_wr) set_vec[BIT_TXI] = 1'b1;
  end

  urf_irq #(.IW(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(wr && !in_id && idx == IX_MASK), .mask_wdata(bus_wdata[IRQ_W-1:0]),
    .raw(raw), .mask(mask), .irq(irq));

  always_comb begin
    full_d = full_q;
    if (data_rd) full_d = 1'b0;
    else if (push && count == CNT_W'(DEPTH - 1)) full_d = 1'b1;
  end

  assign flags = {1'b1, full_q, 1'b0, (count == '0), 4'b0000};

  always_comb begin
    rdata_d = '0;
    if (in_id) rdata_d = DATA_W'(id_byte(bus_addr[4:2]));
    else begin
      case (idx)
        IX_DATA:  rdata_d = DATA_W'(head);
        IX_FLAG:  rdata_d = DATA_W'(flags);
        IX_LPDIV: rdata_d = DATA_W'(lpdiv_q);
        IX_IDIV:  rdata_d = DATA_W'(idiv_q);
        IX_FDIV:  rdata_d = DATA_W'(fdiv_q);
        IX_LINE:  rdata_d = DATA_W'(line_q);
        IX_CTRL:  rdata_d = DATA_W'(ctrl_q);
        IX_LVL:   rdata_d = DATA_W'(lvl_q);
        IX_MASK:  rdata_d = DATA_W'(mask);
        IX_RAW:   rdata_d = DATA_W'(raw);
        IX_MSTAT: rdata_d = DATA_W'(raw & mask);
        IX_DMA:   rdata_d = DATA_W'(dma_q);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpdiv_q <= '0;
      idiv_q  <= '0;
      fdiv_q  <= '0;
      line_q  <= '0;
      ctrl_q  <= 16'h0300;
      lvl_q   <= 6'h12;
      dma_q   <= '0;
      full_q  <= 1'b0;
      rdata_q <= '0;
      txs_q   <= 1'b0;
      txb_q   <= '0;
    end else begin
      full_q <= full_d;
      txs_q  <= data_wr;
      if (data_wr) txb_q <= bus_wdata[7:0];
      if (rd) rdata_q <= rdata_d;
      if (wr && !in_id) begin
        case (idx)
          IX_LPDIV: lpdiv_q <= bus_wdata[7:0];
          IX_IDIV:  idiv_q  <= bus_wdata[15:0];
          IX_FDIV:  fdiv_q  <= bus_wdata[5:0];
          IX_LINE:  line_q  <= bus_wdata[7:0];
          IX_CTRL:  ctrl_q  <= bus_wdata[15:0];
          IX_LVL:   lvl_q   <= bus_wdata[5:0];
          IX_DMA:   dma_q   <= bus_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_strobe = txs_q;
  assign tx_byte   = txb_q;

  a_r6_full_means_16: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (count == CNT_W'(DEPTH)));
  a_r8_tx_raises_raw: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (raw[BIT_TXI] && tx_strobe));
  a_r4_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_q[LINE_QEN] && count != '0) |-> !rx_ready);
  a_r12_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/uart_regfront_test.sv
module uart_regfront_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [16];
  int mrp = 0;
  logic tx_seen;
  logic [7:0] tx_seen_byte;

  always #10 clk = ~clk;

  uart_regfront uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq));

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    tx_seen = tx_strobe; tx_seen_byte = tx_byte;
  endtask

  task automatic expect_reg(input logic [11:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    check(d === e, tag, d, e);
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    @(negedge clk);
    check(rx_ready === 1'b1, tag, {31'd0, rx_ready}, 32'd1);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(irq === 1'b0 && tx_strobe === 1'b0 && rx_ready === 1'b1 && bus_rdata === '0,
          "R1 outputs", {29'd0, irq, tx_strobe, rx_ready}, 32'd1);
    expect_reg(12'h018, 32'h90, "R1 flags");
    expect_reg(12'h034, 32'h12, "R1 level");
    expect_reg(12'h030, 32'h300, "R1 control");
    expect_reg(12'h038, 32'h0, "R1 mask");
    expect_reg(12'h03C, 32'h0, "R1 raw");
    expect_reg(12'h024, 32'h0, "R1 idiv");
  endtask

  task automatic t_ids;
    logic [7:0] ids [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) expect_reg(12'hFE0 + 12'(i * 4), {24'd0, ids[i]}, "R3 id");
  endtask

  task automatic t_storage;
    logic [31:0] d;
    wr(12'h020, 32'h1FF);   wr(12'h024, 32'h1ABCD); wr(12'h028, 32'hFF);
    wr(12'h034, 32'hFF);    wr(12'h048, 32'hF);     wr(12'h030, 32'h12345);
    expect_reg(12'h020, 32'hFF, "R2 lpdiv");
    expect_reg(12'h024, 32'hABCD, "R2 idiv");
    expect_reg(12'h028, 32'h3F, "R2 fdiv");
    expect_reg(12'h034, 32'h3F, "R2 level");
    expect_reg(12'h048, 32'h7, "R2 dma");
    expect_reg(12'h030, 32'h2345, "R2 control");
    wr(12'h018, 32'h0);     expect_reg(12'h018, 32'h90, "R2 flag write ignored");
    wr(12'h01C, 32'hDEAD);  expect_reg(12'h01C, 32'h0, "R2 unmapped read");
    wr(12'hFE0, 32'h55);    expect_reg(12'hFE0, 32'h11, "R2 id write ignored");
    expect_reg(12'h024, 32'hABCD, "R2 unmapped write no effect");
    rd(12'h024, d);
    @(negedge clk); @(negedge clk);
    check(bus_rdata === 32'hABCD, "R12 rdata holds", bus_rdata, 32'hABCD);
  endtask

  task automatic t_single;
    logic [31:0] d;
    push(8'h3C, "R4 ready empty"); mdl[mrp] = 8'h3C;
    check(rx_ready === 1'b0, "R4 single slot full", {31'd0, rx_ready}, 32'd0);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h77; @(negedge clk); rx_valid = 1'b0;
    expect_reg(12'h03C, 32'h10, "R7 rx raw set");
    check(irq === 1'b0, "R9 masked off", {31'd0, irq}, 32'd0);
    wr(12'h038, 32'h10);
    check(irq === 1'b1, "R9 irq after mask", {31'd0, irq}, 32'd1);
    expect_reg(12'h040, 32'h10, "R9 masked status");
    rd(12'h000, d); mrp = (mrp + 1) % 16;
    check(d === 32'h3C, "R5 single data", d, 32'h3C);
    check(irq === 1'b0, "R7 irq clears on drain", {31'd0, irq}, 32'd0);
    expect_reg(12'h03C, 32'h0, "R7 raw cleared");
    expect_reg(12'h018, 32'h90, "R4 dropped byte absent");
  endtask

  task automatic t_full;
    logic [31:0] d;
    wr(12'h02C, 32'h10);
    for (int i = 0; i < 16; i++) begin
      push(8'h40 + 8'(i), "R4 ready deep");
      mdl[(mrp + i) % 16] = 8'h40 + 8'(i);
    end
    check(rx_ready === 1'b0, "R4 deep full", {31'd0, rx_ready}, 32'd0);
    expect_reg(12'h018, 32'hC0, "R6 full flags");
    expect_reg(12'h03C, 32'h10, "R7 raw at 16");
    for (int i = 0; i < 16; i++) begin
      rd(12'h000, d);
      check(d === {24'd0, mdl[mrp]}, "R5 order wrap", d, {24'd0, mdl[mrp]});
      mrp = (mrp + 1) % 16;
      if (i == 0) expect_reg(12'h018, 32'h80, "R6 full clears");
      if (i == 14) expect_reg(12'h03C, 32'h10, "R7 raw held at 1");
    end
    expect_reg(12'h018, 32'h90, "R6 empty flags");
    expect_reg(12'h03C, 32'h0, "R7 raw clear at 0");
  endtask

  task automatic t_empty;
    logic [31:0] d;
    rd(12'h000, d);
    check(d === {24'd0, mdl[mrp]}, "R11 stale read", d, {24'd0, mdl[mrp]});
    expect_reg(12'h018, 32'h90, "R11 count unchanged");
    push(8'hE7, "R11 push after");
    rd(12'h000, d);
    check(d === 32'hE7, "R11 pointer unchanged", d, 32'hE7);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    wr(12'h000, 32'h1A5);
    check(tx_seen === 1'b1 && tx_seen_byte === 8'hA5, "R8 tx strobe", {23'd0, tx_seen, tx_seen_byte}, 32'h1A5);
    @(negedge clk);
    check(tx_strobe === 1'b0, "R8 one cycle", {31'd0, tx_strobe}, 32'd0);
    expect_reg(12'h03C, 32'h20, "R8 tx raw");
    wr(12'h038, 32'h30);
    check(irq === 1'b1, "R9 tx irq", {31'd0, irq}, 32'd1);
    push(8'h5A, "R10 push");
    expect_reg(12'h03C, 32'h30, "R10 both raw");
    wr(12'h044, 32'h20);
    expect_reg(12'h03C, 32'h10, "R10 clear tx only");
    wr(12'h044, 32'h10);
    expect_reg(12'h03C, 32'h0, "R10 clear rx");
    check(irq === 1'b0, "R9 irq low", {31'd0, irq}, 32'd0);
    expect_reg(12'h044, 32'h0, "R2 clear reads 0");
    rd(12'h000, d);
    check(d === 32'h5A, "R5 data after clear", d, 32'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_storage();
    t_single();
    t_full();
    t_empty();
    t_tx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4ms;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule